// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block sits beside a descriptor-driven engine and decides when a completion notification goes out. Each finished descriptor arrives as a one-cycle pulse. The block counts these pulses and raises one notification when either of two limits is met. The first limit is the count reaching a programmed threshold. The second is an elapsed-cycle timer that passes its own threshold while completions are waiting. The timer path takes part only when its enable bit is set.

The notification is a message write, not a level. When the block fires, it presents a 48-bit address and a 32-bit data word on a valid/ready port. A bus master outside this block performs the write. The engine also reports how many completed descriptors it still holds. The block never signals while that number is zero, because a handler would find nothing to service.

Configuration comes in as single-cycle register writes. Each write carries a select code and a 32-bit word.

Top module: `cmpl_irq_coalescer`

## Requirements
- R1: After reset, `msg_valid` is low, and the completion counter and the timer are both zero.
- R2: Register writes use `cfg_wr_sel`, and each select code loads fixed fields of `cfg_wr_data`:
  - Select 0 loads the count threshold from bits [14:0] and the timer enable from bit 18.
  - Select 1 loads the timer threshold from bits [12:0].
  - Select 2 loads address bits [31:0].
  - Select 3 loads address bits [47:32] from data bits [15:0]; the upper data bits are dropped.
  - Select 4 loads the message data word.
  - Reset values are: count threshold 0x14, timer threshold 0xB0, timer disabled, address 0, data 0.
- R3: While idle, a completion pulse increments the counter after the clock edge. When the counter is nonzero and at or above the count threshold at an edge, the block fires at that edge, and `msg_valid` is high after it.
- R4: The timer is zero after the edge that counts the first completion. At each later edge, while the counter is nonzero and the block is idle, the timer increments. With the timer enabled, the block fires at an edge where the counter is nonzero and the timer is at or above the timer threshold.
- R5: With the timer disabled, the block fires only on the count threshold, however long completions wait.
- R6: The block does not fire while `done_count` is zero. A pending condition waits until `done_count` becomes nonzero.
- R7: A firing produces exactly one message, even when both limits are met at the same edge. `msg_valid` stays high until the edge where `msg_ready` is high, and it is low after that edge.
- R8: The address and data are captured from the registers at the firing edge. They stay stable while `msg_valid` is high and `msg_ready` is low, and register writes during that time do not alter them.
- R9: The acceptance edge clears the counter and the timer. Completion pulses are ignored at the firing edge and while a message is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmpl_pulse | input | 1 | One descriptor completed this cycle |
| done_count | input | 15 | Completed descriptors the engine still holds |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select code (see R2) |
| cfg_wr_data | input | 32 | Register write word |
| msg_valid | output | 1 | Message write is presented |
| msg_ready | input | 1 | Message write is taken |
| msg_addr | output | 48 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The bench builds the block with its default widths: a 15-bit counter, a 13-bit timer, a 16-bit upper address and a 32-bit data word. It programs small thresholds at run time, such as 1, 2 and 3 completions and timeouts of 1 and 4 cycles. These values bring every firing path, the same-edge tie of the count and timer limits, and long back-pressure windows within a few dozen cycles. The reset thresholds are checked through the message fields they produce rather than by waiting out 176 cycles.

// File: rtl/coal_pkg.sv
// Shared definitions for the completion interrupt coalescer.
// Assumes a 32-bit configuration write word.
package coal_pkg;
    localparam int REG_W = 32;

    // Register select codes decoded by the configuration block
    typedef enum logic [2:0] {
        SEL_THRESH  = 3'd0,
        SEL_TIMEOUT = 3'd1,
        SEL_ADDR_LO = 3'd2,
        SEL_ADDR_HI = 3'd3,
        SEL_DATA    = 3'd4
    } cfg_sel_e;
endpackage

// File: rtl/coal_cfg_regs.sv
// Configuration registers: thresholds, timer enable, message address and data.
// Assumes single-cycle write strobes; unknown select codes are dropped.
module coal_cfg_regs
    import coal_pkg::*;
#(
    parameter int CNT_W   = 15,
    parameter int TMR_W   = 13,
    parameter int EN_BIT  = 18,
    parameter int ALO_W   = 32,
    parameter int AHI_W   = 16,
    parameter int DATA_W  = 32,
    parameter int RST_THR = 20,
    parameter int RST_TMO = 176,
    localparam int AW     = ALO_W + AHI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  thr,
    output logic              tmr_en,
    output logic [TMR_W-1:0]  tmo,
    output logic [AW-1:0]     addr,
    output logic [DATA_W-1:0] data
);
    logic [ALO_W-1:0] addr_lo;
    logic [AHI_W-1:0] addr_hi;

    // Load the selected register field on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr     <= CNT_W'(RST_THR);
            tmr_en  <= 1'b0;
            tmo     <= TMR_W'(RST_TMO);
            addr_lo <= '0;
            addr_hi <= '0;
            data    <= '0;
        end else if (wr_en) begin
            case (cfg_sel_e'(wr_sel))
                SEL_THRESH: begin
                    thr    <= wr_data[CNT_W-1:0];
                    tmr_en <= wr_data[EN_BIT];
                end
                SEL_TIMEOUT: tmo     <= wr_data[TMR_W-1:0];
                SEL_ADDR_LO: addr_lo <= wr_data[ALO_W-1:0];
                SEL_ADDR_HI: addr_hi <= wr_data[AHI_W-1:0];
                SEL_DATA:    data    <= wr_data[DATA_W-1:0];
                default: ;
            endcase
        end
    end

    // Assemble the full message address
    assign addr = {addr_hi, addr_lo};
endmodule

// File: rtl/coal_trigger.sv
// Completion counter, elapsed timer and firing decision.
// Assumes busy stays high from the firing edge until the acceptance edge.
module coal_trigger #(
    parameter int CNT_W = 15,
    parameter int TMR_W = 13,
    localparam logic [CNT_W-1:0] CNT_MAX = '1,
    localparam logic [TMR_W-1:0] TMR_MAX = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmpl,
    input  logic [CNT_W-1:0] done_count,
    input  logic [CNT_W-1:0] thr,
    input  logic             tmr_en,
    input  logic [TMR_W-1:0] tmo,
    input  logic             busy,
    input  logic             accept,
    output logic             launch
);
    logic [CNT_W-1:0] cnt;
    logic [TMR_W-1:0] tmr;
    logic             count_hit;
    logic             time_hit;

    // Evaluate both limits and gate on idle state and a nonzero done count
    always_comb begin
        count_hit = (cnt != '0) && (cnt >= thr);
        time_hit  = tmr_en && (cnt != '0) && (tmr >= tmo);
        launch    = !busy && (done_count != '0) && (count_hit || time_hit);
    end

    // Count completions and elapsed cycles while idle; clear on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            tmr <= '0;
        end else if (accept) begin
            cnt <= '0;
            tmr <= '0;
        end else if (!busy && !launch) begin
            if (cmpl && cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if (cnt != '0 && tmr != TMR_MAX) tmr <= tmr + 1'b1;
        end
    end

    // R9
    clear_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cnt == '0 && tmr == '0));
    // R9
    frozen_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !accept) |=> ($stable(cnt) && $stable(tmr)));
    // R5
    no_timeout_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !tmr_en) |-> (cnt >= thr));
    // R1
    timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (tmr == '0));
endmodule

// File: rtl/coal_msg_out.sv
// Message holder: captures address and data at firing and presents them
// on a valid/ready port until taken. Assumes launch only while idle.
module coal_msg_out #(
    parameter int AW     = 48,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [AW-1:0]     src_addr,
    input  logic [DATA_W-1:0] src_data,
    input  logic              ready,
    output logic              valid,
    output logic [AW-1:0]     addr,
    output logic [DATA_W-1:0] data
);
    // Raise valid on launch, drop it on acceptance, capture the payload once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            addr  <= '0;
            data  <= '0;
        end else if (valid) begin
            if (ready) valid <= 1'b0;
        end else if (launch) begin
            valid <= 1'b1;
            addr  <= src_addr;
            data  <= src_data;
        end
    end

    // R7
    hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> valid);
    // R7
    drop_after_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> !valid);
    // R8
    payload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> ($stable(addr) && $stable(data)));
endmodule

// File: rtl/cmpl_irq_coalescer.sv
// Completion interrupt coalescer top: configuration, trigger and message port.
// Assumes one completion pulse per cycle at most and a synchronous reset.
module cmpl_irq_coalescer
    import coal_pkg::*;
#(
    parameter int CNT_W  = 15,
    parameter int TMR_W  = 13,
    parameter int EN_BIT = 18,
    parameter int ALO_W  = 32,
    parameter int AHI_W  = 16,
    parameter int DATA_W = 32,
    localparam int AW    = ALO_W + AHI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmpl_pulse,
    input  logic [CNT_W-1:0]  done_count,
    input  logic              cfg_wr_en,
    input  logic [2:0]        cfg_wr_sel,
    input  logic [REG_W-1:0]  cfg_wr_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [AW-1:0]     msg_addr,
    output logic [DATA_W-1:0] msg_data
);
    logic [CNT_W-1:0]  thr;
    logic              tmr_en;
    logic [TMR_W-1:0]  tmo;
    logic [AW-1:0]     cfg_addr;
    logic [DATA_W-1:0] cfg_data;
    logic              launch;
    logic              accept;

    // Acceptance of the presented message
    assign accept = msg_valid && msg_ready;

    coal_cfg_regs #(
        .CNT_W(CNT_W), .TMR_W(TMR_W), .EN_BIT(EN_BIT),
        .ALO_W(ALO_W), .AHI_W(AHI_W), .DATA_W(DATA_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
        .thr(thr), .tmr_en(tmr_en), .tmo(tmo),
        .addr(cfg_addr), .data(cfg_data)
    );

    coal_trigger #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_trig (
        .clk(clk), .rst_n(rst_n),
        .cmpl(cmpl_pulse), .done_count(done_count),
        .thr(thr), .tmr_en(tmr_en), .tmo(tmo),
        .busy(msg_valid), .accept(accept), .launch(launch)
    );

    coal_msg_out #(.AW(AW), .DATA_W(DATA_W)) u_msg (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .src_addr(cfg_addr), .src_data(cfg_data),
        .ready(msg_ready), .valid(msg_valid),
        .addr(msg_addr), .data(msg_data)
    );

    // R6
    no_spurious_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> ($past(done_count) != '0));
    // R1
    idle_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !msg_valid);
endmodule

// File: tb/cmpl_irq_coalescer_test.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module cmpl_irq_coalescer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmpl_pulse = 1'b0;
    logic [14:0] done_count = '0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [47:0] msg_addr;
    logic [31:0] msg_data;

    int  tests = 0;
    int  fails = 0;
    int  taken = 0;
    longint last_data = 0;
    bit  finished = 1'b0;

    // reference model state
    int     m_cnt, m_tmr, m_valid, m_thr, m_ten, m_tmo;
    longint m_alo, m_ahi, m_dat, m_addr, m_data;

    always #2 clk = ~clk;

    cmpl_irq_coalescer uut (
        .clk(clk), .rst_n(rst_n), .cmpl_pulse(cmpl_pulse),
        .done_count(done_count), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model, updated at each rising edge from its pre-edge state
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_tmr = 0; m_valid = 0;
            m_thr = 20; m_ten = 0; m_tmo = 176;
            m_alo = 0; m_ahi = 0; m_dat = 0; m_addr = 0; m_data = 0;
        end else begin
            bit fire;
            fire = (m_valid == 0) && (done_count != 0) && (m_cnt != 0) &&
                   ((m_cnt >= m_thr) || (m_ten != 0 && m_tmr >= m_tmo));
            if (m_valid != 0) begin
                if (msg_ready) begin m_valid = 0; m_cnt = 0; m_tmr = 0; end
            end else if (fire) begin
                m_valid = 1;
                m_addr = (m_ahi << 32) | m_alo;
                m_data = m_dat;
            end else begin
                if (m_cnt != 0 && m_tmr < 8191) m_tmr++;
                if (cmpl_pulse && m_cnt < 32767) m_cnt++;
            end
            if (cfg_wr_en) begin
                case (cfg_wr_sel)
                    3'd0: begin m_thr = int'(cfg_wr_data & 32'h7FFF); m_ten = int'(cfg_wr_data[18]); end
                    3'd1: m_tmo = int'(cfg_wr_data & 32'h1FFF);
                    3'd2: m_alo = longint'(cfg_wr_data);
                    3'd3: m_ahi = longint'(cfg_wr_data & 32'hFFFF);
                    3'd4: m_dat = longint'(cfg_wr_data);
                    default: ;
                endcase
            end
        end
    end

    // Compare outputs against the model away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(msg_valid == (m_valid != 0), "R7 valid", longint'(msg_valid), longint'(m_valid));
            if (msg_valid) begin
                chk(msg_addr == m_addr[47:0], "R8 addr", longint'(msg_addr), m_addr);
                chk(msg_data == m_data[31:0], "R8 data", longint'(msg_data), m_data);
                if (msg_ready) begin taken++; last_data = longint'(msg_data); end
            end
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cmpl_pulse = 1'b1;
        end
        @(negedge clk); cmpl_pulse = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(msg_valid == 1'b0, "R1 reset valid", longint'(msg_valid), 0);

        // R2 fields: high address keeps only 16 bits
        wr(3'd2, 32'hDEAD_0000);
        wr(3'd3, 32'h0001_2345);
        wr(3'd4, 32'h0000_CAFE);
        wr(3'd0, 32'h0000_0003);
        done_count = 15'd7;
        // R3 count threshold
        base = taken;
        pulse(3); idle(4);
        chk(taken - base == 1, "R3 one msg on count", taken - base, 1);
        chk(last_data == 64'hCAFE, "R2 data field", last_data, 64'hCAFE);

        // R4 timeout path enabled
        wr(3'd1, 32'hFFFF_E004);
        wr(3'd0, 32'h0004_0014);
        base = taken;
        pulse(1); idle(10);
        chk(taken - base == 1, "R4 timeout msg", taken - base, 1);

        // R5 timer disabled, below count threshold
        wr(3'd0, 32'h0000_0014);
        base = taken;
        pulse(2); idle(40);
        chk(taken - base == 0, "R5 no timeout msg", taken - base, 0);
        wr(3'd0, 32'h0000_0001);
        idle(4);
        chk(taken - base == 1, "R5 count still fires", taken - base, 1);

        // R6 done count zero holds the message back
        done_count = 15'd0;
        base = taken;
        pulse(1); idle(6);
        chk(taken - base == 0, "R6 held at zero", taken - base, 0);
        done_count = 15'd3;
        idle(3);
        chk(taken - base == 1, "R6 released", taken - base, 1);

        // R8 R9 back-pressure: write and completions during pending message
        msg_ready = 1'b0;
        base = taken;
        pulse(1); idle(2);
        chk(msg_valid == 1'b1, "R7 held high", longint'(msg_valid), 1);
        wr(3'd4, 32'h0000_BEEF);
        pulse(2); idle(3);
        msg_ready = 1'b1;
        idle(6);
        chk(taken - base == 1, "R9 pending pulses ignored", taken - base, 1);
        chk(last_data == 64'hCAFE, "R8 captured data", last_data, 64'hCAFE);

        // R7 both limits at the same edge
        wr(3'd1, 32'h0000_0001);
        wr(3'd0, 32'h0004_0002);
        base = taken;
        pulse(2); idle(8);
        chk(taken - base == 1, "R7 single msg on tie", taken - base, 1);
        chk(last_data == 64'hBEEF, "R2 new data", last_data, 64'hBEEF);

        // R1 reset mid-run clears everything
        pulse(1);
        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
        chk(msg_valid == 1'b0, "R1 after reset", longint'(msg_valid), 0);
        idle(5);
        finish_run();
    end
endmodule